// File: doc/BRIEF.md
# Programmable Counter Timebase Controller

This block holds a free-running up-counter and the mode register that drives it. The mode register chooses one of six increment sources:
- the system clock;
- the system clock divided by 4;
- the system clock divided by 12;
- a timer-0 overflow pulse;
- falling edges on an external event pin;
- an asynchronous external clock divided by 8.

Every source becomes a single-cycle increment enable in the system-clock domain, so the counter itself runs on one clock.

The counter can be told to pause while the processor reports idle. When the counter wraps from all ones to zero it sets an overflow flag. The flag stays set until a dedicated clear strobe arrives. An interrupt request follows the flag, gated by an enable bit.

The same register holds a watchdog-enable bit and a lock bit, and exports both. While the watchdog enable is set, the register accepts only a write that clears that enable. Once the lock is set, the register accepts no write at all until reset.

Top module: `tbc_timebase`

## Requirements
- R1: After reset the mode register reads 0x40 (watchdog enable set, every other bit clear), the count is 0, the overflow flag is 0 and the interrupt request is 0.
- R2: Timebase field mode[3:1] = 100 adds one per system clock, 001 adds one every 4 system clocks, and 000 adds one every 12 system clocks.
- R3: With mode[3:1] = 010, the count rises by one for each single-cycle high pulse on t0_ovf_i and does not rise otherwise.
- R4: With mode[3:1] = 011, the count rises by one for each high-to-low transition of evt_pin_i. This holds when each level lasts at least two system clocks, and rising edges add nothing.
- R5: With mode[3:1] = 101, the count rises by one for every 8 rising edges of ext_clk_i, counted from reset. Four edges from reset add nothing, and sixteen edges add two.
- R6: Reserved timebase codes 110 and 111 never increment the count.
- R7: With mode[7] = 1, the count holds while idle_i is high. With mode[7] = 0, idle_i has no effect.
- R8: A wrap from 0xFFFF to 0x0000 sets ovf_flag_o. The flag stays set until ovf_clr_i is pulsed, and a wrap in the same cycle as the clear wins.
- R9: irq_o is high exactly when ovf_flag_o is high and mode[0] = 1.
- R10: While mode[6] = 1 and mode[5] = 0, a write with data bit 6 = 0 clears only mode[6], and a write with data bit 6 = 1 changes nothing.
- R11: Once mode[5] = 1, every write is ignored and wdog_en_o and wdog_lock_o keep their values until reset.
- R12: mode[4] always reads 0, whatever is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_i | input | 1 | Processor idle status |
| t0_ovf_i | input | 1 | Timer-0 overflow pulse, one system clock wide |
| evt_pin_i | input | 1 | Asynchronous external event pin |
| ext_clk_i | input | 1 | Asynchronous external clock |
| wr_en_i | input | 1 | Mode register write strobe |
| wr_data_i | input | 8 | Mode register write data |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| rd_data_o | output | 8 | Mode register read value |
| count_o | output | 16 | Counter value |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Overflow interrupt request |
| wdog_en_o | output | 1 | Watchdog enable bit |
| wdog_lock_o | output | 1 | Watchdog lock bit |

## Verification
Each timebase code is given the same fixed 48-cycle window. The counts 48, 12, 4 and 0 separate the undivided, divide-by-4, divide-by-12 and silent sources, so a miswired select code shows up as the wrong number. Idle is raised with the hold bit both set and clear, which separates a hold that works from one that is ignored or always applied. Event pulses, timer-0 pulses and external clock edges are issued in known numbers, so a wrong edge polarity or a wrong divider count gives a different delta. Write sequences run from the watchdog-enabled, unlocked and locked states, which tells the write-protect path apart from the lock path.

// File: rtl/tbc_pkg.sv
package tbc_pkg;

    localparam int MODE_W = 8;
    localparam logic [MODE_W-1:0] MODE_RST_BITS = 8'h40;

    typedef enum logic [2:0] {
        TB_DIV12   = 3'd0,
        TB_DIV4    = 3'd1,
        TB_T0OVF   = 3'd2,
        TB_EVFALL  = 3'd3,
        TB_SYSCLK  = 3'd4,
        TB_EXTDIV8 = 3'd5,
        TB_RSV6    = 3'd6,
        TB_RSV7    = 3'd7
    } tb_sel_e;

    // bit 7 idle hold, 6 watchdog enable, 5 lock, 4 spare, 3:1 select, 0 irq enable
    typedef struct packed {
        logic    idle_hold;
        logic    wd_en;
        logic    wd_lock;
        logic    spare;
        tb_sel_e sel;
        logic    ovf_ie;
    } mode_t;

    // Next mode value for a write, applying the lock and write-protect rules
    function automatic mode_t mode_next(mode_t cur, logic [MODE_W-1:0] wr);
        mode_t nxt;
        nxt = cur;
        if (cur.wd_lock) begin
            nxt = cur;
        end else if (cur.wd_en) begin
            if (!wr[6]) nxt.wd_en = 1'b0;
        end else begin
            nxt       = mode_t'(wr);
            nxt.spare = 1'b0;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tbc_edge_sync.sv
module tbc_edge_sync #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic edge_o
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              synced;

    assign synced = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], async_i};
            prev  <= synced;
        end
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev & ~synced;
        end else begin : g_rise
            assign edge_o = ~prev & synced;
        end
    endgenerate
endmodule

// File: rtl/tbc_divider.sv
module tbc_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic pulse_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign pulse_o = tick_i && (cnt == LAST);
endmodule

// File: rtl/tbc_src_mux.sv
module tbc_src_mux
    import tbc_pkg::*;
(
    input  tb_sel_e sel_i,
    input  logic    div12_i,
    input  logic    div4_i,
    input  logic    t0_i,
    input  logic    evfall_i,
    input  logic    extdiv_i,
    output logic    tick_o
);
    always_comb begin
        case (sel_i)
            TB_DIV12:   tick_o = div12_i;
            TB_DIV4:    tick_o = div4_i;
            TB_T0OVF:   tick_o = t0_i;
            TB_EVFALL:  tick_o = evfall_i;
            TB_SYSCLK:  tick_o = 1'b1;
            TB_EXTDIV8: tick_o = extdiv_i;
            default:    tick_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tbc_mode_reg.sv
module tbc_mode_reg
    import tbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [MODE_W-1:0] wr_data_i,
    output mode_t             mode_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= mode_t'(MODE_RST_BITS);
        end else if (wr_en_i) begin
            mode_o <= mode_next(mode_o, wr_data_i);
        end
    end
endmodule

// File: rtl/tbc_timebase.sv
module tbc_timebase
    import tbc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int DIV_EXT     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_i,
    input  logic             t0_ovf_i,
    input  logic             evt_pin_i,
    input  logic             ext_clk_i,
    input  logic             wr_en_i,
    input  logic [7:0]       wr_data_i,
    input  logic             ovf_clr_i,
    output logic [7:0]       rd_data_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_flag_o,
    output logic             irq_o,
    output logic             wdog_en_o,
    output logic             wdog_lock_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    mode_t mode;
    logic  div12_p, div4_p, ev_fall, ext_rise, ext_p, tick, step, wrap;

    tbc_mode_reg u_mode (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .mode_o(mode)
    );

    tbc_divider #(.DIV(DIV_SLOW)) u_div_slow (
        .clk(clk), .rst(rst), .tick_i(1'b1), .pulse_o(div12_p)
    );
    tbc_divider #(.DIV(DIV_FAST)) u_div_fast (
        .clk(clk), .rst(rst), .tick_i(1'b1), .pulse_o(div4_p)
    );

    tbc_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b1)) u_evt (
        .clk(clk), .rst(rst), .async_i(evt_pin_i), .edge_o(ev_fall)
    );
    tbc_edge_sync #(.STAGES(SYNC_STAGES), .FALLING(1'b0)) u_ext (
        .clk(clk), .rst(rst), .async_i(ext_clk_i), .edge_o(ext_rise)
    );
    tbc_divider #(.DIV(DIV_EXT)) u_div_ext (
        .clk(clk), .rst(rst), .tick_i(ext_rise), .pulse_o(ext_p)
    );

    tbc_src_mux u_mux (
        .sel_i(mode.sel), .div12_i(div12_p), .div4_i(div4_p), .t0_i(t0_ovf_i),
        .evfall_i(ev_fall), .extdiv_i(ext_p), .tick_o(tick)
    );

    assign step = tick && !(mode.idle_hold && idle_i);
    assign wrap = step && (count_o == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (step) begin
            count_o <= count_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_flag_o <= 1'b0;
        end else if (wrap) begin
            ovf_flag_o <= 1'b1;
        end else if (ovf_clr_i) begin
            ovf_flag_o <= 1'b0;
        end
    end

    assign irq_o       = ovf_flag_o && mode.ovf_ie;
    assign rd_data_o   = mode;
    assign wdog_en_o   = mode.wd_en;
    assign wdog_lock_o = mode.wd_lock;
endmodule

// File: rtl/tbc_timebase_chk.sv
module tbc_timebase_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             idle_i,
    input logic             wr_en_i,
    input logic             ovf_clr_i,
    input logic [7:0]       rd_data_o,
    input logic [CNT_W-1:0] count_o,
    input logic             ovf_flag_o,
    input logic             irq_o,
    input logic             wdog_en_o,
    input logic             wdog_lock_o
);
    // R12
    spare_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[4] == 1'b0);

    // R8
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(count_o) == {CNT_W{1'b1}} && count_o == '0) |-> ovf_flag_o);

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == (ovf_flag_o && rd_data_o[0]));

    // R11
    lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_lock_o |=> ($stable(rd_data_o) && wdog_lock_o));

    // R10
    guard_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wdog_en_o && !wdog_lock_o && wr_en_i) |=>
        ((rd_data_o & 8'hBF) == ($past(rd_data_o) & 8'hBF)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[7] && idle_i) |=> $stable(count_o));
endmodule

bind tbc_timebase tbc_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .idle_i(idle_i), .wr_en_i(wr_en_i), .ovf_clr_i(ovf_clr_i),
    .rd_data_o(rd_data_o), .count_o(count_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o),
    .wdog_en_o(wdog_en_o), .wdog_lock_o(wdog_lock_o)
);

// File: tb/sim_tbc_timebase.sv
module sim_tbc_timebase;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        idle = 1'b0, t0 = 1'b0, evt = 1'b1, extc = 1'b0;
    logic        wr_en = 1'b0, clr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd;
    logic [15:0] cnt;
    logic        flag, irq, wen, wlock;

    int errors = 0;
    int checks = 0;
    logic [15:0] c0;

    always #(CLK_P/2) clk = ~clk;

    tbc_timebase u0 (
        .clk(clk), .rst(rst), .idle_i(idle), .t0_ovf_i(t0), .evt_pin_i(evt),
        .ext_clk_i(extc), .wr_en_i(wr_en), .wr_data_i(wr_data), .ovf_clr_i(clr),
        .rd_data_o(rd), .count_o(cnt), .ovf_flag_o(flag), .irq_o(irq),
        .wdog_en_o(wen), .wdog_lock_o(wlock)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  mode;
        logic        idl;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 8'h08, 1'b0, 16'd48},  // R2 system clock
        '{4'd2, 8'h02, 1'b0, 16'd12},  // R2 divide by 4
        '{4'd2, 8'h00, 1'b0, 16'd4},   // R2 divide by 12
        '{4'd6, 8'h0C, 1'b0, 16'd0},   // R6 reserved 110
        '{4'd6, 8'h0E, 1'b0, 16'd0},   // R6 reserved 111
        '{4'd7, 8'h88, 1'b1, 16'd0},   // R7 hold while idle
        '{4'd7, 8'h08, 1'b1, 16'd48},  // R7 idle ignored
        '{4'd7, 8'h80, 1'b0, 16'd4},   // R7 hold set, not idle
        '{4'd3, 8'h04, 1'b0, 16'd0}    // R3 no pulses, no counts
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_mode(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check(rd == 8'h40, "R1 mode", rd, 8'h40);
        check(cnt == 16'd0 && !flag && !irq, "R1 count/flag", {cnt, flag, irq}, 0);
        check(wen && !wlock, "R1 wdog bits", {wen, wlock}, 2'b10);

        // R10 write with bit 6 set while enabled: ignored
        write_mode(8'hCF);
        check(rd == 8'h40, "R10 ignored write", rd, 8'h40);
        // R10 write with bit 6 clear: only enable clears
        write_mode(8'h8F);
        check(rd == 8'h00 && !wen, "R10 clear enable only", rd, 8'h00);

        // R12 spare bit
        write_mode(8'h18);
        check(rd == 8'h08, "R12 spare bit", rd, 8'h08);

        for (int i = 0; i < NV; i++) begin
            write_mode(VECS[i].mode);
            idle = VECS[i].idl;
            hold(2);
            c0 = cnt;
            hold(48);
            check(cnt - c0 == VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i),
                  int'(cnt - c0), int'(VECS[i].exp));
            idle = 1'b0;
        end

        // R3 timer-0 pulses
        write_mode(8'h04);
        hold(2);
        c0 = cnt;
        for (int k = 0; k < 3; k++) begin
            t0 = 1'b1; hold(1); t0 = 1'b0; hold(2);
        end
        hold(2);
        check(cnt - c0 == 16'd3, "R3 timer-0 pulses", int'(cnt - c0), 3);

        // R4 falling edges on event pin
        write_mode(8'h06);
        hold(4);
        c0 = cnt;
        for (int k = 0; k < 5; k++) begin
            evt = 1'b0; hold(2); evt = 1'b1; hold(2);
        end
        hold(4);
        check(cnt - c0 == 16'd5, "R4 event edges", int'(cnt - c0), 5);

        // R8 / R9 overflow with interrupt enabled
        write_mode(8'h09);
        for (int k = 0; k < 70000; k++) begin
            @(negedge clk);
            if (flag) break;
        end
        check(flag && cnt == 16'd0, "R8 wrap sets flag", {cnt, flag}, 1);
        check(irq, "R9 irq with enable", irq, 1);
        hold(3);
        check(flag, "R8 flag held", flag, 1);
        write_mode(8'h08);
        check(flag && !irq, "R9 irq masked", irq, 0);
        @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
        check(!flag, "R8 clear strobe", flag, 0);

        // R5 external clock divided by 8, counted from reset
        do_reset();
        write_mode(8'h00);
        write_mode(8'h0A);
        hold(2);
        c0 = cnt;
        for (int k = 0; k < 4; k++) begin
            extc = 1'b1; hold(2); extc = 1'b0; hold(2);
        end
        hold(4);
        check(cnt == c0, "R5 four edges", int'(cnt - c0), 0);
        for (int k = 0; k < 12; k++) begin
            extc = 1'b1; hold(2); extc = 1'b0; hold(2);
        end
        hold(4);
        check(cnt - c0 == 16'd2, "R5 sixteen edges", int'(cnt - c0), 2);

        // R11 lock
        write_mode(8'h60);
        check(rd == 8'h60 && wen && wlock, "R11 lock set", rd, 8'h60);
        write_mode(8'h00);
        check(rd == 8'h60, "R11 clear ignored", rd, 8'h60);
        write_mode(8'hFF);
        check(rd == 8'h60 && wen && wlock, "R11 write ignored", rd, 8'h60);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule